// File: doc/BRIEF.md
# Transmit Completion Pointer with Compare-Acknowledge Interrupt

This block keeps the completion pointer of a single transmit queue and drives a level interrupt towards the host. When the DMA engine finishes a packet, it reports the address of the last descriptor it processed through a write strobe. The block stores that address and marks an interrupt as pending. The value written does not matter for raising the interrupt. A write of zero raises it just as any other value does.

The host acknowledges by writing a value through its register port. That value is never stored. The block compares it with the pointer it holds. If the two are equal, the pending interrupt clears. If they differ, both the pointer and the interrupt stay as they were. The host can read the stored pointer back at any time, and a read has no side effect. A mask bit gates the pending flag onto the interrupt output without changing the flag itself.

Top module: `cmpl_irq_top`

## Requirements
- R1: A port-side write (`port_wr_en`=1) stores `port_wr_addr` as the completion pointer. A read issued in the following cycle returns that value.
- R2: Every port-side write sets the pending flag, whatever address it carries, zero included.
- R3: A host write never changes the stored completion pointer.
- R4: A host write whose data equals the stored pointer clears the pending flag. When no port write occurs in the same cycle, the comparison uses the pointer held before that clock edge.
- R5: A host write whose data differs from the stored pointer leaves the pending flag unchanged.
- R6: `irq_out` is registered and equals pending AND `irq_enable`, both as they stand after the same clock edge. Deasserting `irq_enable` does not clear the pending flag.
- R7: When a port write and a host write fall in the same cycle, the port write wins. The pointer takes the new address, and the flag is pending afterwards, even if the host data matched the old pointer.
- R8: A synchronous active-high reset clears the pointer, the pending flag, `irq_out` and `host_rd_data` to zero.
- R9: When `host_rd_en`=1, `host_rd_data` takes the stored pointer, as it stood before that edge, one cycle later. A read changes neither the pending flag nor the pointer. `host_rd_data` holds its value while `host_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_wr_en | input | 1 | DMA engine write strobe |
| port_wr_addr | input | PTR_W | Descriptor address written by the DMA engine |
| host_wr_en | input | 1 | Host acknowledge write strobe |
| host_wr_data | input | PTR_W | Acknowledge value, compared and never stored |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | PTR_W | Registered read-back of the stored pointer |
| irq_enable | input | 1 | Interrupt mask, 1 lets the pending flag through |
| irq_out | output | 1 | Registered level interrupt |

## Verification
With a 4-bit pointer, the bench loads every possible pointer value and then sweeps all 16 acknowledge values against each one. This separates a true equality compare from a partial or inverted compare, and it shows that acknowledge data never lands in the pointer. Writes of zero show that raising the interrupt does not depend on the value. Masked intervals show that the mask only gates the output and does not clear the flag. Colliding port and host writes, with host data equal to the old pointer, tell the correct port-wins priority apart from an acknowledge that takes precedence.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;

  // Kind of update applied to the pending flag in a cycle
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_PORT = 2'd1,
    UPD_ACK  = 2'd2,
    UPD_MISS = 2'd3
  } upd_kind_e;

endpackage

// File: rtl/cmpl_upd_arb.sv
module cmpl_upd_arb
  import cmpl_irq_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             port_wr_en,
  input  logic             host_wr_en,
  input  logic [PTR_W-1:0] host_wr_data,
  input  logic [PTR_W-1:0] ptr_q,
  output upd_kind_e        kind
);

  // The port write has priority; the host compare only counts when the port is idle
  always_comb begin
    if (port_wr_en)                  kind = UPD_PORT;
    else if (!host_wr_en)            kind = UPD_NONE;
    else if (host_wr_data == ptr_q)  kind = UPD_ACK;
    else                             kind = UPD_MISS;
  end

endmodule

// File: rtl/cmpl_ptr_store.sv
module cmpl_ptr_store #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_wr_en,
  input  logic [PTR_W-1:0] port_wr_addr,
  input  logic             host_wr_en,
  output logic [PTR_W-1:0] ptr_q
);

  always_ff @(posedge clk) begin
    if (rst)             ptr_q <= '0;
    else if (port_wr_en) ptr_q <= port_wr_addr;
  end

  p_port_store_r1: assert property (@(posedge clk) disable iff (rst)
    port_wr_en |=> ptr_q == $past(port_wr_addr));

  p_host_no_store_r3: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && !port_wr_en) |=> $stable(ptr_q));

endmodule

// File: rtl/cmpl_pend_flag.sv
module cmpl_pend_flag
  import cmpl_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  upd_kind_e kind,
  output logic      pend_d,
  output logic      pend_q
);

  always_comb begin
    unique case (kind)
      UPD_PORT: pend_d = 1'b1;
      UPD_ACK:  pend_d = 1'b0;
      default:  pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_d;
  end

  p_port_raise_r2: assert property (@(posedge clk) disable iff (rst)
    (kind == UPD_PORT) |=> pend_q);

  p_match_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (kind == UPD_ACK) |=> !pend_q);

  p_miss_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (kind == UPD_MISS) |=> pend_q == $past(pend_q));

endmodule

// File: rtl/cmpl_irq_top.sv
module cmpl_irq_top
  import cmpl_irq_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_wr_en,
  input  logic [PTR_W-1:0] port_wr_addr,
  input  logic             host_wr_en,
  input  logic [PTR_W-1:0] host_wr_data,
  input  logic             host_rd_en,
  output logic [PTR_W-1:0] host_rd_data,
  input  logic             irq_enable,
  output logic             irq_out
);

  logic [PTR_W-1:0] ptr_q;
  upd_kind_e        kind;
  logic             pend_d;
  logic             pend_q;
  logic [PTR_W-1:0] rd_q;
  logic             irq_q;

  cmpl_ptr_store #(.PTR_W(PTR_W)) u_store (
    .clk          (clk),
    .rst          (rst),
    .port_wr_en   (port_wr_en),
    .port_wr_addr (port_wr_addr),
    .host_wr_en   (host_wr_en),
    .ptr_q        (ptr_q)
  );

  cmpl_upd_arb #(.PTR_W(PTR_W)) u_arb (
    .port_wr_en   (port_wr_en),
    .host_wr_en   (host_wr_en),
    .host_wr_data (host_wr_data),
    .ptr_q        (ptr_q),
    .kind         (kind)
  );

  cmpl_pend_flag u_pend (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .pend_d (pend_d),
    .pend_q (pend_q)
  );

  // Registered output: reflects pending and mask as they stand after this edge
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend_d & irq_enable;
  end

  always_ff @(posedge clk) begin
    if (rst)             rd_q <= '0;
    else if (host_rd_en) rd_q <= ptr_q;
  end

  assign irq_out      = irq_q;
  assign host_rd_data = rd_q;

  p_irq_needs_pend_r6: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> pend_q);

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && irq_enable && !host_wr_en) |=> irq_out);

  p_mask_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !irq_enable && !host_wr_en) |=> pend_q && !irq_out);

  p_port_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (port_wr_en && host_wr_en) |=> pend_q && ptr_q == $past(port_wr_addr));

  p_read_r9: assert property (@(posedge clk) disable iff (rst)
    host_rd_en |=> host_rd_data == $past(ptr_q));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !host_rd_en |=> $stable(host_rd_data));

endmodule

// File: tb/cmpl_irq_top_tb.sv
module cmpl_irq_top_tb;

  localparam int W       = 4;
  localparam int CLK_PER = 10;
  localparam int NVAL    = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         port_wr_en = 1'b0;
  logic [W-1:0] port_wr_addr = '0;
  logic         host_wr_en = 1'b0;
  logic [W-1:0] host_wr_data = '0;
  logic         host_rd_en = 1'b0;
  logic [W-1:0] host_rd_data;
  logic         irq_enable = 1'b1;
  logic         irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic         exp_pend;
  logic [W-1:0] exp_ptr;

  always #(CLK_PER/2) clk = ~clk;

  cmpl_irq_top #(.PTR_W(W)) u_dut (
    .clk(clk), .rst(rst),
    .port_wr_en(port_wr_en), .port_wr_addr(port_wr_addr),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .irq_enable(irq_enable), .irq_out(irq_out)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic port_write(input logic [W-1:0] a);
    port_wr_en = 1'b1; port_wr_addr = a;
    @(negedge clk);
    port_wr_en = 1'b0;
    exp_ptr = a; exp_pend = 1'b1;
  endtask

  task automatic host_write(input logic [W-1:0] d);
    host_wr_en = 1'b1; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
    if (d == exp_ptr) exp_pend = 1'b0;
  endtask

  task automatic read_check(input string tag);
    host_rd_en = 1'b1;
    @(negedge clk);
    host_rd_en = 1'b0;
    check(host_rd_data == exp_ptr, tag, int'(host_rd_data), int'(exp_ptr));
  endtask

  task automatic irq_check(input string tag);
    logic e;
    e = exp_pend & irq_enable;
    check(irq_out == e, tag, int'(irq_out), int'(e));
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_pend = 1'b0; exp_ptr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(irq_out == 1'b0, "R8 irq after reset", int'(irq_out), 0);
    check(host_rd_data == '0, "R8 rd_data after reset", int'(host_rd_data), 0);
    read_check("R8 pointer after reset");
    // R4 with nothing pending: matching write keeps flag low
    host_write('0);
    irq_check("R4 ack with nothing pending");

    // Exhaustive sweep: every stored value against every ack value
    for (int v = 0; v < NVAL; v++) begin
      port_write(W'(v));
      irq_check("R2 raise after port write");
      read_check("R1 stored pointer");
      for (int h = 0; h < NVAL; h++) begin
        logic was;
        was = exp_pend;
        host_write(W'(h));
        if (h == v) irq_check("R4 matching ack clears");
        else if (was) irq_check("R5 mismatch keeps pending");
        else irq_check("R5 mismatch after clear stays low");
        read_check("R3 host write not stored");
        if (h == v) port_write(W'(v));
      end
      check(irq_out == 1'b1, "R2 rewrite raises", int'(irq_out), 1);
      host_write(W'(v));
    end

    // R2: zero address still raises
    port_write('0);
    irq_check("R2 zero address raises");

    // R6: mask gates output, keeps pending
    irq_enable = 1'b0;
    @(negedge clk);
    irq_check("R6 masked output low");
    repeat (3) @(negedge clk);
    irq_enable = 1'b1;
    @(negedge clk);
    irq_check("R6 unmask shows kept pending");
    irq_enable = 1'b0;
    host_write(4'd9);
    irq_enable = 1'b1;
    @(negedge clk);
    irq_check("R5 mismatch while masked");
    host_write('0);
    irq_check("R4 ack clears after unmask");

    // R9: reads have no side effect on pending
    port_write(4'd6);
    for (int k = 0; k < 4; k++) read_check("R9 repeated read");
    irq_check("R9 read keeps pending");
    @(negedge clk);
    check(host_rd_data == 4'd6, "R9 rd_data holds", int'(host_rd_data), 6);

    // R7: collision with matching host data, port wins
    host_write(4'd6);
    irq_check("R4 ack before collision");
    port_wr_en = 1'b1; port_wr_addr = 4'd11;
    host_wr_en = 1'b1; host_wr_data = 4'd6;
    @(negedge clk);
    port_wr_en = 1'b0; host_wr_en = 1'b0;
    exp_ptr = 4'd11; exp_pend = 1'b1;
    irq_check("R7 port wins collision");
    read_check("R7 pointer takes port value");
    // collision where host data equals the new value
    port_wr_en = 1'b1; port_wr_addr = 4'd3;
    host_wr_en = 1'b1; host_wr_data = 4'd3;
    @(negedge clk);
    port_wr_en = 1'b0; host_wr_en = 1'b0;
    exp_ptr = 4'd3; exp_pend = 1'b1;
    irq_check("R7 port wins equal-data collision");
    host_write(4'd3);
    irq_check("R4 ack after collision");

    // R8: reset mid-run
    port_write(4'd12);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_ptr = '0; exp_pend = 1'b0;
    irq_check("R8 irq after second reset");
    read_check("R8 pointer after second reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule